// File: doc/BRIEF.md
# Edge Wake-Up Controller with Oscillator Settle Delay

This block watches a group of input pins while the processor is stopped and brings it back when one of them shows a chosen transition. Each pin has an enable bit and a polarity bit. Polarity 1 detects a high-to-low transition and polarity 0 detects a low-to-high transition. Pin 3 is the serial receive line, so enabling it with polarity 1 lets the falling start bit of an incoming character wake the device. Every pin passes through a synchronizer before edge detection. A detected edge sets a per-pin pending flag, and software clears that flag by writing a 1 to it.

Two strobes stop execution: one for halt and one for idle. The block leaves its stopped state as soon as the wake request is high. After idle, or after halt with no crystal in use, the run-enable output returns on the next clock. After halt with a crystal in use, run-enable is held low for a further fixed settle count, which gives the oscillator time to stabilise. The pending flags keep working in every state.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, `pend` is all zeros, `wake_req` is 0 and `run_en` is 1.
- R2: While `run_en` is 1, a pulse on `halt_req` or `idle_req` drops `run_en` on the next clock. If both are high together, halt is taken. While stopped, both strobes are ignored.
- R3: A pending bit is set only when its `en_mask` bit is 1. A transition on a disabled pin leaves its pending bit at 0.
- R4: With `fall_sel[i]`=1, only a high-to-low transition on pin i sets `pend[i]`. With `fall_sel[i]`=0, only a low-to-high transition sets it. Transitions in the other direction are ignored. Bit 3 is the serial receive pin, and it is handled like every other bit.
- R5: A pin change applied between clock edges appears in `pend` after the third rising edge that follows it: two synchronizer stages plus one edge-detect stage.
- R6: A pending bit stays set until a cycle in which `clr_wr`=1 and the matching `clr_mask` bit is 1. Bits whose mask bit is 0 are untouched. An edge detected in the same cycle as the clear wins.
- R7: `wake_req` is the combinational OR of `pend & en_mask`. Disabling a pin masks its pending bit at once without clearing it.
- R8: After idle, or after halt with `xtal_used`=0, `run_en` returns to 1 on the clock edge after the one where `wake_req` is first seen high.
- R9: After halt with `xtal_used`=1, `run_en` returns exactly SETTLE_CYCLES (default 256) clocks later than in R8. A settle, once started, runs to completion even if `wake_req` falls.
- R10: Changing `fall_sel` while a pin holds a steady level never sets its pending bit. The new polarity is registered and takes effect one clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Asynchronous pins being watched; bit 3 is the serial receive line |
| en_mask | input | NPINS | Per-pin enable for wake detection |
| fall_sel | input | NPINS | Per-pin polarity: 1 = high-to-low, 0 = low-to-high |
| clr_wr | input | 1 | Clear strobe for pending bits |
| clr_mask | input | NPINS | Pending bits to clear when `clr_wr` is 1 |
| halt_req | input | 1 | Halt entry strobe |
| idle_req | input | 1 | Idle entry strobe |
| xtal_used | input | 1 | A crystal oscillator drives the clock, so a settle delay is needed after halt |
| pend | output | NPINS | Per-pin pending flags |
| wake_req | output | 1 | OR of the enabled pending flags |
| run_en | output | 1 | Execution allowed |

## Verification
A polarity register or synchronizer stage that is wrong shows up in `pend` within three clocks of a pin change, either as a missing flag or as a flag on a pin that saw the wrong direction of transition. A wrong state in the wake sequencer appears on `run_en` one clock after `wake_req` rises. An off-by-one in the settle counter only becomes visible at the single clock that ends the settle window, so both neighbouring clocks of that window are sampled.

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl #(
  parameter int NPINS         = 8,
  parameter int SETTLE_CYCLES = 256,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] en_mask,
  input  logic [NPINS-1:0] fall_sel,
  input  logic             clr_wr,
  input  logic [NPINS-1:0] clr_mask,
  input  logic             halt_req,
  input  logic             idle_req,
  input  logic             xtal_used,
  output logic [NPINS-1:0] pend,
  output logic             wake_req,
  output logic             run_en
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_IDLE, ST_SETTLE} st_t;

  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0] prev_q, sel_q, cur, rise, fall, hit, clr_bits;
  logic [SYNC_STAGES:0] arm_q;
  logic [CW-1:0] cnt;
  st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
      arm_q  <= '0;
      sel_q  <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[SYNC_STAGES-1];
      arm_q  <= {arm_q[SYNC_STAGES-1:0], 1'b1};
      sel_q  <= fall_sel;
    end
  end

  assign cur      = sync_q[SYNC_STAGES-1];
  assign rise     = cur & ~prev_q;
  assign fall     = ~cur & prev_q;
  assign hit      = arm_q[SYNC_STAGES] ? ((sel_q & fall) | (~sel_q & rise)) : '0;
  assign clr_bits = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_bits) | (hit & en_mask);
  end

  assign wake_req = |(pend & en_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (halt_req)      st <= ST_HALT;
          else if (idle_req) st <= ST_IDLE;
        end
        ST_HALT: if (wake_req) begin
          st  <= xtal_used ? ST_SETTLE : ST_RUN;
          cnt <= '0;
        end
        ST_IDLE: if (wake_req) st <= ST_RUN;
        default: begin
          if (cnt == CNT_LAST) st <= ST_RUN;
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign run_en = (st == ST_RUN);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && run_en));

  a_r2_stop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (halt_req || idle_req)) |=> !run_en);

  a_r3_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en_mask)) == '0));

  a_r6_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr_bits) & ~pend) == '0));

  a_r8_fast_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE || (st == ST_HALT && !xtal_used)) && wake_req) |=> run_en);

  a_r9_crystal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && xtal_used && wake_req) |=> !run_en);

  a_r9_settle_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETTLE && cnt != CNT_LAST) |=> (st == ST_SETTLE && !run_en));

endmodule

// File: tb/wake_edge_ctrl_tb.sv
module wake_edge_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] pin_in, en_mask, fall_sel, clr_mask, pend;
  logic clr_wr, halt_req, idle_req, xtal_used, wake_req, run_en;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .en_mask(en_mask),
    .fall_sel(fall_sel), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .halt_req(halt_req), .idle_req(idle_req), .xtal_used(xtal_used),
    .pend(pend), .wake_req(wake_req), .run_en(run_en)
  );

  // {from, to, enable, polarity, expected pend}
  localparam logic [39:0] VEC [0:8] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF},
    {8'h00, 8'hFF, 8'h0F, 8'h00, 8'h0F},
    {8'hAA, 8'h55, 8'hFF, 8'hFF, 8'hAA},
    {8'hAA, 8'h55, 8'hFF, 8'h00, 8'h55},
    {8'hF0, 8'h0F, 8'h3C, 8'h30, 8'h3C},
    {8'h08, 8'h00, 8'h08, 8'h08, 8'h08},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_mask = 8'hFF;
    tick(1);
    clr_wr = 1'b0; clr_mask = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; en_mask = '0; fall_sel = '0; clr_wr = 1'b0;
    clr_mask = '0; halt_req = 1'b0; idle_req = 1'b0; xtal_used = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 pend", pend, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 run_en", run_en, 1);
    tick(5);

    for (int i = 0; i < 9; i++) begin
      en_mask = VEC[i][23:16]; fall_sel = VEC[i][15:8]; pin_in = VEC[i][39:32];
      tick(6);
      clear_all();
      tick(1);
      pin_in = VEC[i][31:24];
      tick(6);
      chk("R3/R4 table pend", pend, VEC[i][7:0]);
    end
    clear_all();

    // R5 latency, R7 wake
    en_mask = 8'h01; fall_sel = 8'h00; pin_in = 8'h00;
    tick(6); clear_all(); tick(1);
    pin_in = 8'h01;
    tick(2);
    chk("R5 not yet", pend, 8'h00);
    tick(1);
    chk("R5 third edge", pend, 8'h01);
    chk("R7 wake on", wake_req, 1);
    en_mask = 8'h00; #1;
    chk("R7 masked", wake_req, 0);
    chk("R6 kept when masked", pend, 8'h01);

    // R6 partial clear
    tick(1);
    en_mask = 8'hFF; pin_in = 8'hFF;
    tick(6);
    chk("R6 all set", pend, 8'hFF);
    clr_wr = 1'b1; clr_mask = 8'h0F; tick(1); clr_wr = 1'b0;
    chk("R6 partial clear", pend, 8'hF0);
    clear_all();

    // R10 polarity toggling on steady pins
    for (int k = 0; k < 4; k++) begin
      fall_sel = ~fall_sel; tick(1);
    end
    tick(4);
    chk("R10 no false edge", pend, 8'h00);

    // R2 idle entry, halt ignored while stopped, R8 idle resume
    en_mask = 8'h08; fall_sel = 8'h08; pin_in = 8'hFF;
    tick(6); clear_all();
    idle_req = 1'b1; tick(1); idle_req = 1'b0;
    chk("R2 idle stops", run_en, 0);
    xtal_used = 1'b1; halt_req = 1'b1; tick(1); halt_req = 1'b0;
    pin_in = 8'hF7;
    tick(3);
    chk("R8 wake seen", wake_req, 1);
    chk("R8 still stopped", run_en, 0);
    tick(1);
    chk("R8 idle resume (R2 halt ignored)", run_en, 1);

    // R8 halt without crystal
    pin_in = 8'hFF; tick(6); clear_all();
    xtal_used = 1'b0;
    halt_req = 1'b1; tick(1); halt_req = 1'b0;
    chk("R2 halt stops", run_en, 0);
    pin_in = 8'hF7;
    tick(3);
    chk("R8 halt no xtal wait", run_en, 0);
    tick(1);
    chk("R8 halt no xtal resume", run_en, 1);

    // R9 halt with crystal, both strobes (R2 priority), clear during settle
    pin_in = 8'hFF; tick(6); clear_all();
    xtal_used = 1'b1;
    halt_req = 1'b1; idle_req = 1'b1; tick(1); halt_req = 1'b0; idle_req = 1'b0;
    pin_in = 8'hF7;
    tick(3);
    chk("R9 wake seen", wake_req, 1);
    clr_wr = 1'b1; clr_mask = 8'hFF; tick(1); clr_wr = 1'b0;
    chk("R9 settling", run_en, 0);
    tick(255);
    chk("R9 last settle cycle (R2 halt wins)", run_en, 0);
    tick(1);
    chk("R9 resume after settle", run_en, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule